// File: doc/BRIEF.md
# Service-Level Input Port Buffer

This block is the receive side of one router port. Flits of 16 bits arrive from an upstream router or processing unit. Each flit carries a two-bit service-level code in bits [15:14] and a two-bit flit kind in bits [13:12]. The block sorts every accepted flit into one of two first-in first-out queues, one per service level. Because each level has its own queue, a stalled level never holds back the other one.

Each queue shows the crossbar three things: its oldest flit, a not-empty flag, and the routing target of the packet now leaving it. The target is taken from bits [11:8] of a packet's header flit. It stays in force for the body flits that follow, until the flit that ends the packet has been read out. This gives wormhole forwarding. Any output port can pop a queue by raising that level's read line for this input. A free-slot count per level lets the upstream sender check for space before it sends.

Top module: `lane_ingress_buffer`

## Requirements
- R1: A flit with service-level code 2'b11 in bits [15:14] goes to lane 0 (signaling). Code 2'b10 goes to lane 1 (read/write). The flit kind sits in bits [13:12], and every bit of an accepted flit is stored unchanged.
- R2: The block never stores a flit of kind 2'b00 (idle), nor a flit whose service-level code is 2'b00 or 2'b01. Free slots stay the same after such a flit.
- R3: A flit sent to a lane whose queue already holds DEPTH entries is dropped, even if a read of that lane happens in the same cycle. The drop sets that lane's overflow flag, and the flag stays set until reset.
- R4: Each lane delivers flits in arrival order. A flit written at one clock edge shows at the head from that edge on. The lane pops at an edge where any of its NUM_OUT read lines is high and the lane is not empty.
- R5: A read line raised for an empty lane has no effect.
- R6: A read and a write on the same non-full lane in one cycle both take effect, so the occupancy does not change.
- R7: A lane's header is the first flit it presents after reset, or the first after an end-of-packet flit (kind 2'b10) or a single-flit packet (kind 2'b11) has been popped. While a header is at the head, the route output shows its bits [11:8]. After the header is popped, the route output holds that value until the packet's closing flit has been popped.
- R8: The two lanes are independent. A full or overflowed lane does not change what the other lane accepts or reports.
- R9: After reset both lanes are empty, each reports DEPTH free slots, and both overflow flags are clear.
- R10: The free-slot output of each lane always equals DEPTH minus its occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flitIn | input | 16 | Incoming flit; an idle kind means no flit |
| readLines | input | 2*NUM_OUT | Read requests; bit lane*NUM_OUT+k comes from output port k for that lane |
| headFlit | output | 2*16 | Oldest flit of each lane; lane l in bits [16l+15:16l] |
| headValid | output | 2 | Lane is not empty |
| headRoute | output | 2*4 | Routing target in force for each lane |
| freeSlots | output | 2*CNT_W | Free entries per lane; CNT_W = clog2(DEPTH+1) |
| overflow | output | 2 | Sticky flag per lane: a flit was dropped because the lane was full |

## Verification
The hardest case to reach is a full lane that receives a write and a read in the same cycle. The write must be dropped even though a slot opens at that edge. A second hard case is a packet whose route must survive while a later header is already queued behind it. The stimulus first fills a lane with no reads, then pulses a read together with a write. A behavioural queue model compared on every clock checks the heads, routes and counts. A long random phase with mixed kinds, reserved codes and sparse reads keeps both lanes near full while packets interleave.

// File: rtl/lane_ingress_pkg.sv
package lane_ingress_pkg;
  localparam int LANES   = 2;
  localparam int FLIT_W  = 16;
  localparam int ROUTE_W = 4;
  localparam int ROUTE_LO = 8;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'b00,
    KIND_BODY = 2'b01,
    KIND_END  = 2'b10,
    KIND_FULL = 2'b11
  } flit_kind_e;

  localparam logic [1:0] LEVEL_SIG = 2'b11;
  localparam logic [1:0] LEVEL_RW  = 2'b10;

  typedef struct packed {
    logic [LANES-1:0] push;
    logic [LANES-1:0] pop;
    logic [LANES-1:0] startSel;
  } lane_strobe_t;
endpackage

// File: rtl/lane_ingress_ctrl.sv
module lane_ingress_ctrl
  import lane_ingress_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int NUM_OUT = 5,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [3:0]                 flitTag,
  input  logic [LANES*NUM_OUT-1:0]   readLines,
  input  logic [2*LANES-1:0]         headKind,
  output lane_strobe_t               strobe,
  output logic [CNT_W-1:0]           occ [LANES],
  output logic [LANES-1:0]           overflow
);
  logic [1:0] levelCode;
  logic [1:0] kindCode;
  logic [LANES-1:0] laneHit;
  logic [LANES-1:0] pushV, popV, atStart;

  assign levelCode = flitTag[3:2];
  assign kindCode  = flitTag[1:0];

  always_comb begin
    laneHit = '0;
    if (kindCode != KIND_IDLE) begin
      if (levelCode == LEVEL_SIG)     laneHit[0] = 1'b1;
      else if (levelCode == LEVEL_RW) laneHit[1] = 1'b1;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic anyRd, isFull, isEmpty;
    logic [1:0] popKind;
    assign anyRd   = |readLines[l*NUM_OUT +: NUM_OUT];
    assign isFull  = (occ[l] == CNT_W'(DEPTH));
    assign isEmpty = (occ[l] == '0);
    assign popKind = headKind[2*l +: 2];
    assign pushV[l] = laneHit[l] && !isFull;
    assign popV[l]  = anyRd && !isEmpty;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        occ[l]      <= '0;
        overflow[l] <= 1'b0;
        atStart[l]  <= 1'b1;
      end else begin
        occ[l] <= occ[l] + CNT_W'(pushV[l]) - CNT_W'(popV[l]);
        if (laneHit[l] && isFull) overflow[l] <= 1'b1;
        if (popV[l]) atStart[l] <= (popKind == KIND_END) || (popKind == KIND_FULL);
      end
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      occ[l] <= CNT_W'(DEPTH)); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      overflow[l] |=> overflow[l]); // R3
    AST_IDLE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
      (kindCode == KIND_IDLE) |=> (occ[l] <= $past(occ[l]))); // R2
    AST_QUIET_LANE: assert property (@(posedge clk) disable iff (!rstN)
      (!anyRd && !laneHit[l]) |=> $stable(occ[l])); // R5
  end

  assign strobe = '{push: pushV, pop: popV, startSel: atStart};
endmodule

// File: rtl/lane_ingress_dp.sv
module lane_ingress_dp
  import lane_ingress_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [FLIT_W-1:0]   flitIn,
  input  lane_strobe_t        strobe,
  input  logic [LANES-1:0]    laneValid,
  output logic [FLIT_W-1:0]   headFlit [LANES],
  output logic [ROUTE_W-1:0]  headRoute [LANES],
  output logic [2*LANES-1:0]  headKind
);
  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [FLIT_W-1:0]  store [DEPTH];
    logic [PTR_W-1:0]   wrPtr, rdPtr;
    logic [ROUTE_W-1:0] routeHeld;
    logic [ROUTE_W-1:0] headField;

    assign headFlit[l]       = store[rdPtr];
    assign headField         = headFlit[l][ROUTE_LO +: ROUTE_W];
    assign headKind[2*l +: 2] = headFlit[l][13:12];
    assign headRoute[l]      = strobe.startSel[l] ? headField : routeHeld;

    always_ff @(posedge clk) begin
      if (strobe.push[l]) store[wrPtr] <= flitIn;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr     <= '0;
        rdPtr     <= '0;
        routeHeld <= '0;
      end else begin
        if (strobe.push[l]) wrPtr <= stepPtr(wrPtr);
        if (strobe.pop[l]) begin
          rdPtr <= stepPtr(rdPtr);
          if (strobe.startSel[l]) routeHeld <= headField;
        end
      end
    end

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (laneValid[l] && !strobe.pop[l]) |=> $stable(headFlit[l])); // R4
    AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (laneValid[l] && !strobe.pop[l] && !strobe.startSel[l]) |=> $stable(headRoute[l])); // R7
  end
endmodule

// File: rtl/lane_ingress_buffer.sv
module lane_ingress_buffer
  import lane_ingress_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int NUM_OUT = 5,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [FLIT_W-1:0]          flitIn,
  input  logic [LANES*NUM_OUT-1:0]   readLines,
  output logic [LANES*FLIT_W-1:0]    headFlit,
  output logic [LANES-1:0]           headValid,
  output logic [LANES*ROUTE_W-1:0]   headRoute,
  output logic [LANES*CNT_W-1:0]     freeSlots,
  output logic [LANES-1:0]           overflow
);
  lane_strobe_t       strobe;
  logic [CNT_W-1:0]   occ [LANES];
  logic [2*LANES-1:0] headKind;
  logic [FLIT_W-1:0]  laneFlit [LANES];
  logic [ROUTE_W-1:0] laneRoute [LANES];

  lane_ingress_ctrl #(.DEPTH(DEPTH), .NUM_OUT(NUM_OUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .flitTag(flitIn[15:12]), .readLines(readLines),
    .headKind(headKind), .strobe(strobe), .occ(occ), .overflow(overflow));

  lane_ingress_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .flitIn(flitIn), .strobe(strobe),
    .laneValid(headValid), .headFlit(laneFlit), .headRoute(laneRoute),
    .headKind(headKind));

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign headValid[l]                   = (occ[l] != '0);
    assign freeSlots[l*CNT_W +: CNT_W]    = CNT_W'(DEPTH) - occ[l];
    assign headFlit[l*FLIT_W +: FLIT_W]   = laneFlit[l];
    assign headRoute[l*ROUTE_W +: ROUTE_W] = laneRoute[l];
  end
endmodule

// File: tb/lane_ingress_buffer_test.sv
`timescale 1ns/1ps
module lane_ingress_buffer_test;
  localparam int DEPTH = 4;
  localparam int NOUT  = 5;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam real PER  = 4.0;

  logic clk = 0, rstN = 0;
  logic [15:0] flitIn = '0;
  logic [2*NOUT-1:0] readLines = '0;
  logic [31:0] headFlit;
  logic [1:0]  headValid;
  logic [7:0]  headRoute;
  logic [2*CW-1:0] freeSlots;
  logic [1:0]  overflow;

  int compared = 0, mismatched = 0;
  logic [15:0] mq [2][$];
  bit mOvf [2];
  bit mStart [2];
  logic [3:0] mRoute [2];

  always #(PER/2) clk = ~clk;

  lane_ingress_buffer #(.DEPTH(DEPTH), .NUM_OUT(NOUT)) uut (
    .clk(clk), .rstN(rstN), .flitIn(flitIn), .readLines(readLines),
    .headFlit(headFlit), .headValid(headValid), .headRoute(headRoute),
    .freeSlots(freeSlots), .overflow(overflow));

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk(input logic [1:0] lvl, input logic [1:0] kind,
                                     input logic [11:0] data);
    return {lvl, kind, data};
  endfunction

  task automatic modelReset();
    for (int l = 0; l < 2; l++) begin
      mq[l].delete(); mOvf[l] = 0; mStart[l] = 1; mRoute[l] = 0;
    end
  endtask

  task automatic modelStep(input logic [15:0] f, input logic [2*NOUT-1:0] rd);
    int tgt;
    tgt = -1;
    if (f[13:12] != 2'b00) begin
      if (f[15:14] == 2'b11) tgt = 0;
      else if (f[15:14] == 2'b10) tgt = 1;
    end
    for (int l = 0; l < 2; l++) begin
      bit doPush, wasFull;
      logic [15:0] h;
      wasFull = (mq[l].size() == DEPTH);
      doPush = (tgt == l) && !wasFull;
      if ((tgt == l) && wasFull) mOvf[l] = 1;
      if ((|rd[l*NOUT +: NOUT]) && mq[l].size() > 0) begin
        h = mq[l].pop_front();
        if (mStart[l]) mRoute[l] = h[11:8];
        mStart[l] = (h[13:12] == 2'b10) || (h[13:12] == 2'b11);
      end
      if (doPush) mq[l].push_back(f);
    end
  endtask

  task automatic compareAll();
    for (int l = 0; l < 2; l++) begin
      check("R4 valid", int'(headValid[l]), int'(mq[l].size() > 0));
      check("R10 free", int'(freeSlots[l*CW +: CW]), DEPTH - mq[l].size());
      check("R3 overflow", int'(overflow[l]), int'(mOvf[l]));
      if (mq[l].size() > 0) begin
        check("R1 head", int'(headFlit[l*16 +: 16]), int'(mq[l][0]));
        check("R7 route", int'(headRoute[l*4 +: 4]),
              int'(mStart[l] ? mq[l][0][11:8] : mRoute[l]));
      end
    end
  endtask

  task automatic tick(input logic [15:0] f, input logic [2*NOUT-1:0] rd);
    flitIn = f; readLines = rd;
    @(posedge clk);
    modelStep(f, rd);
    @(negedge clk);
    compareAll();
  endtask

  localparam logic [9:0] RD0 = 10'b00000_00100;
  localparam logic [9:0] RD1 = 10'b01000_00000;

  bit finished = 0;

  initial begin
    #(PER * 200000);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R9 reset state
    check("R9 valid", int'(headValid), 0);
    check("R9 free", int'(freeSlots), {CW'(DEPTH), CW'(DEPTH)});
    check("R9 overflow", int'(overflow), 0);
    // R2 reserved levels and idle kind
    tick(mk(2'b01, 2'b11, 12'h5AA), '0);
    tick(mk(2'b00, 2'b01, 12'h3BB), '0);
    tick(mk(2'b11, 2'b00, 12'h7CC), '0);
    tick('0, '0);
    check("R2 free", int'(freeSlots), {CW'(DEPTH), CW'(DEPTH)});
    // R5 read of empty lanes
    tick('0, RD0 | RD1);
    check("R5 free", int'(freeSlots), {CW'(DEPTH), CW'(DEPTH)});
    // R1 R7 lane 0 packet with route 5, lane 1 single-flit route 9
    tick(mk(2'b11, 2'b01, 12'h512), '0);
    check("R1 lane0 head", int'(headFlit[15:0]), 16'hD512);
    check("R7 header route", int'(headRoute[3:0]), 5);
    tick(mk(2'b10, 2'b11, 12'h9AB), '0);
    check("R1 lane1 head", int'(headFlit[31:16]), 16'hB9AB);
    tick(mk(2'b11, 2'b01, 12'hE01), '0);
    tick(mk(2'b11, 2'b10, 12'hF02), '0);
    tick(mk(2'b11, 2'b11, 12'h3C3), RD0); // header popped
    check("R7 held route", int'(headRoute[3:0]), 5);
    tick('0, RD0);
    check("R7 held through body", int'(headRoute[3:0]), 5);
    tick('0, RD0);                        // end popped
    check("R7 next header route", int'(headRoute[3:0]), 3);
    tick('0, RD0 | RD1);
    check("R4 drained", int'(headValid), 0);
    // R3 R8 fill lane 1 and overflow it
    for (int i = 0; i < DEPTH; i++) tick(mk(2'b10, 2'b01, 12'(i)), '0);
    tick(mk(2'b10, 2'b10, 12'h0EE), '0);
    check("R3 lane1 overflow", int'(overflow[1]), 1);
    check("R8 lane0 untouched", int'(overflow[0]), 0);
    tick(mk(2'b11, 2'b11, 12'h1AA), '0);
    check("R8 lane0 accepts", int'(freeSlots[CW-1:0]), DEPTH - 1);
    // R3 full lane, write plus read in same cycle: write dropped
    tick(mk(2'b10, 2'b10, 12'h0DD), RD1);
    check("R3 full write dropped", int'(freeSlots[2*CW-1:CW]), 1);
    // R6 non-full read plus write
    tick(mk(2'b10, 2'b10, 12'h0CC), RD1);
    check("R6 occupancy held", int'(freeSlots[2*CW-1:CW]), 1);
    // reset again, then random traffic
    @(negedge clk); rstN = 0; flitIn = '0; readLines = '0;
    @(posedge clk); modelReset(); @(negedge clk); rstN = 1;
    check("R9 overflow cleared", int'(overflow), 0);
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] f;
      logic [9:0] rd;
      f = 16'($urandom);
      if (($urandom % 4) == 0) f[15:14] = 2'($urandom);
      else f[15:14] = {1'b1, 1'($urandom)};
      rd = '0;
      if (($urandom % 3) == 0) rd[$urandom % 5] = 1'b1;
      if (($urandom % 3) == 0) rd[5 + $urandom % 5] = 1'b1;
      tick(f, rd);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule